// File: doc/BRIEF.md
# Narrow-width add/subtract execution unit

This unit decodes and executes a family of 32-bit add and subtract instructions for a small integer core with sixteen architectural registers. Every instruction forms a full sum or difference and then narrows it: the byte or halfword part of the result is sign-extended or zero-extended back to a register-wide value. The width and signedness of the result come from the funct3 field, using the same type coding as the load/store size field. The register-register forms add or subtract two source operands. The immediate forms add a constant taken from the instruction word.

The pipeline stage presents an instruction word with a valid strobe, together with the two source operand values it has read from the register file. One clock later the unit shows either a result with its destination index and a result-valid pulse, or an illegal-instruction pulse. A rejected instruction leaves the previous result and index untouched. The register file and all other instructions are handled elsewhere.

Top module: `narrow_arith_unit`

## Requirements
- R1: One clock after a cycle with `in_valid` high, exactly one of `out_valid` (legal instruction) and `out_illegal` (rejected instruction) is high for one cycle. After a cycle with `in_valid` low, both are low.
- R2: Register forms use opcode bits 6:0 = 0111011. funct7 (bits 31:25) = 0000000 computes rs1 + rs2, and funct7 = 0100000 computes rs1 - rs2, before extension.
- R3: funct3 (bits 14:12) = 000 gives a signed byte result: bits 31:8 are all copies of bit 7 of the sum.
- R4: funct3 = 001 gives a signed halfword result: bits 31:16 are all copies of bit 15 of the sum.
- R5: funct3 = 100 gives an unsigned byte result: bits 7:0 of the sum are kept and bits 31:8 are zero.
- R6: funct3 = 101 gives an unsigned halfword result: bits 15:0 of the sum are kept and bits 31:16 are zero.
- R7: Immediate forms use opcode 0011011 and always add. For funct3 000 and 100 the immediate is the unsigned 8-bit value in bits 27:20, and bits 31:28 must be 0000.
- R8: For immediate forms with funct3 001 and 101, the immediate is bits 31:20, sign-extended from bit 31. Bits 31:28 may take any value.
- R9: An instruction is illegal if any of these holds: its opcode is neither of the two above; funct3 is outside {000, 001, 100, 101}; it is a register form whose funct7 is neither value of R2; it is a byte immediate form with nonzero bits 31:28; rd (bits 11:7) or rs1 (bits 19:15) is 16 or more; or it is a register form whose rs2 (bits 24:20) is 16 or more. The rs2 field is not checked in immediate forms.
- R10: On a legal instruction, `out_rd` takes bits 10:7 of the instruction. After an illegal instruction or an idle cycle, `out_data` and `out_rd` keep their previous values.
- R11: A synchronous reset clears `out_data`, `out_rd`, `out_valid` and `out_illegal` to zero on the next clock edge, even if `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The instruction and operands on the inputs are to be executed this cycle |
| in_insn | input | 32 | Instruction word |
| in_src_a | input | 32 | Value of the first source register |
| in_src_b | input | 32 | Value of the second source register (ignored by immediate forms) |
| out_data | output | 32 | Registered, extended result |
| out_rd | output | 4 | Registered destination register index |
| out_valid | output | 1 | One-cycle pulse: a legal instruction completed |
| out_illegal | output | 1 | One-cycle pulse: the presented instruction was rejected |

## Verification
The in-design properties assume that `in_valid` is a known level at every rising edge. They also assume that the funct3 bits seen one cycle before a result belong to the instruction that produced it, so `in_insn` must stay steady across the sampling edge. The properties further assume that reset is high from the first edge. The stimulus meets all of this: it asserts reset at time zero, and it changes the instruction, operands and strobe only on falling edges, so each word is stable for the whole half cycle around the capturing edge. The stimulus covers each extension type, both add and subtract, and both immediate kinds. It also includes every illegal condition, including a register index of 16 or more in each checked field.

// File: rtl/narrow_arith_pkg.sv
package narrow_arith_pkg;

   localparam int INSN_W  = 32;
   localparam int HALF_W  = 16;
   localparam int BYTE_W  = 8;
   localparam int FIELD_W = 5;

   localparam logic [6:0] OPC_IMM_FORM = 7'b0011011;
   localparam logic [6:0] OPC_REG_FORM = 7'b0111011;
   localparam logic [6:0] F7_PLUS      = 7'b0000000;
   localparam logic [6:0] F7_MINUS     = 7'b0100000;

   // result type, coded like the load/store size field
   typedef enum logic [2:0] {
      KIND_SBYTE = 3'b000,
      KIND_SHALF = 3'b001,
      KIND_UBYTE = 3'b100,
      KIND_UHALF = 3'b101
   } kind_t;

   typedef struct packed {
      logic              legal;
      logic              is_sub;
      logic              use_imm;
      kind_t             kind;
      logic [HALF_W-1:0] imm;
   } dec_t;

endpackage

// File: rtl/narrow_arith_decode.sv
module narrow_arith_decode
   import narrow_arith_pkg::*;
#(
   parameter int NREGS = 16,
   localparam int IDX_W = $clog2(NREGS)
) (
   input  logic [INSN_W-1:0] insn,
   output dec_t              dec,
   output logic [IDX_W-1:0]  rd_idx
);

   localparam int LIM_W = FIELD_W + 1;
   localparam logic [LIM_W-1:0] IDX_LIMIT = LIM_W'(NREGS);

   logic [6:0]         opc;
   logic [2:0]         f3;
   logic [6:0]         f7;
   logic [FIELD_W-1:0] rd_f, rs1_f, rs2_f;
   logic [3:0]         top_nib;
   logic [7:0]         uimm8;
   logic [11:0]        imm12;

   logic is_imm, is_reg, f3_ok, f7_ok, nib_ok, idx_ok, byte_type;

   function automatic logic in_range(input logic [FIELD_W-1:0] f);
      return {1'b0, f} < IDX_LIMIT;
   endfunction

   always_comb begin
      opc     = insn[6:0];
      rd_f    = insn[11:7];
      f3      = insn[14:12];
      rs1_f   = insn[19:15];
      rs2_f   = insn[24:20];
      f7      = insn[31:25];
      top_nib = insn[31:28];
      uimm8   = insn[27:20];
      imm12   = insn[31:20];
   end

   always_comb begin
      is_imm    = (opc == OPC_IMM_FORM);
      is_reg    = (opc == OPC_REG_FORM);
      byte_type = ~f3[0];
      unique case (f3)
         3'b000, 3'b001, 3'b100, 3'b101: f3_ok = 1'b1;
         default:                        f3_ok = 1'b0;
      endcase
      f7_ok  = !is_reg || (f7 == F7_PLUS) || (f7 == F7_MINUS);
      nib_ok = !is_imm || !byte_type || (top_nib == 4'b0000);
      idx_ok = in_range(rd_f) && in_range(rs1_f) && (!is_reg || in_range(rs2_f));

      dec.legal   = (is_imm || is_reg) && f3_ok && f7_ok && nib_ok && idx_ok;
      dec.use_imm = is_imm;
      dec.is_sub  = is_reg && (f7 == F7_MINUS);
      dec.kind    = f3_ok ? kind_t'(f3) : KIND_SBYTE;
      dec.imm     = byte_type ? {{(HALF_W-BYTE_W){1'b0}}, uimm8}
                              : {{(HALF_W-12){imm12[11]}}, imm12};
      rd_idx      = rd_f[IDX_W-1:0];
   end

   // R9: a byte immediate with a nonzero top nibble never passes
   always_comb begin
      if (is_imm && byte_type && top_nib != 4'b0000)
         a_r9_nibble_reject: assert (!dec.legal);
   end

endmodule

// File: rtl/narrow_arith_addsub.sv
module narrow_arith_addsub #(
   parameter int W     = 16,
   parameter int STYLE = 0
) (
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   input  logic         sub,
   output logic [W-1:0] sum
);

   generate
      if (STYLE != 0 && STYLE != 1) begin : g_bad_style
         $error("narrow_arith_addsub: STYLE must be 0 or 1");
      end
      if (STYLE == 0) begin : g_shared
         // one carry chain: invert the second operand and carry in for minus
         logic [W-1:0] opb_x;
         always_comb begin
            opb_x = opb ^ {W{sub}};
            sum   = opa + opb_x + W'(sub);
         end
      end else begin : g_split
         logic [W-1:0] plus_v, minus_v;
         always_comb begin
            plus_v  = opa + opb;
            minus_v = opa - opb;
            sum     = sub ? minus_v : plus_v;
         end
      end
   endgenerate

endmodule

// File: rtl/narrow_arith_extend.sv
module narrow_arith_extend
   import narrow_arith_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [HALF_W-1:0] narrow,
   input  kind_t             kind,
   output logic [XLEN-1:0]   wide
);

   generate
      if (XLEN <= HALF_W) begin : g_bad_xlen
         $error("narrow_arith_extend: XLEN must exceed the halfword width");
      end
   endgenerate

   logic [BYTE_W-1:0] lo_byte;
   logic [HALF_W-1:0] lo_half;

   always_comb begin
      lo_byte = narrow[BYTE_W-1:0];
      lo_half = narrow;
      unique case (kind)
         KIND_SBYTE: wide = {{(XLEN-BYTE_W){lo_byte[BYTE_W-1]}}, lo_byte};
         KIND_SHALF: wide = {{(XLEN-HALF_W){lo_half[HALF_W-1]}}, lo_half};
         KIND_UBYTE: wide = {{(XLEN-BYTE_W){1'b0}}, lo_byte};
         KIND_UHALF: wide = {{(XLEN-HALF_W){1'b0}}, lo_half};
         default:    wide = '0;
      endcase
   end

endmodule

// File: rtl/narrow_arith_unit.sv
module narrow_arith_unit
   import narrow_arith_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int NREGS       = 16,
   parameter int ADDER_STYLE = 0,
   localparam int IDX_W      = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [INSN_W-1:0] in_insn,
   input  logic [XLEN-1:0]   in_src_a,
   input  logic [XLEN-1:0]   in_src_b,
   output logic [XLEN-1:0]   out_data,
   output logic [IDX_W-1:0]  out_rd,
   output logic              out_valid,
   output logic              out_illegal
);

   generate
      if (NREGS < 2 || NREGS > 32 || (NREGS & (NREGS - 1)) != 0) begin : g_bad_nregs
         $error("narrow_arith_unit: NREGS must be a power of two from 2 to 32");
      end
      if (XLEN <= HALF_W) begin : g_bad_xlen
         $error("narrow_arith_unit: XLEN must exceed the halfword width");
      end
   endgenerate

   dec_t              dec;
   logic [IDX_W-1:0]  rd_idx;
   logic [HALF_W-1:0] opb_narrow, sum_narrow;
   logic [XLEN-1:0]   ext_val;
   logic              take;

   // upper operand bits never reach the narrowed result
   logic [2*(XLEN-HALF_W)-1:0] src_hi_unused;
   assign src_hi_unused = {in_src_a[XLEN-1:HALF_W], in_src_b[XLEN-1:HALF_W]};

   narrow_arith_decode #(.NREGS(NREGS)) u_dec (
      .insn   (in_insn),
      .dec    (dec),
      .rd_idx (rd_idx)
   );

   assign opb_narrow = dec.use_imm ? dec.imm : in_src_b[HALF_W-1:0];

   narrow_arith_addsub #(.W(HALF_W), .STYLE(ADDER_STYLE)) u_add (
      .opa (in_src_a[HALF_W-1:0]),
      .opb (opb_narrow),
      .sub (dec.is_sub),
      .sum (sum_narrow)
   );

   narrow_arith_extend #(.XLEN(XLEN)) u_ext (
      .narrow (sum_narrow),
      .kind   (dec.kind),
      .wide   (ext_val)
   );

   assign take = in_valid && dec.legal;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_data    <= '0;
         out_rd      <= '0;
         out_valid   <= 1'b0;
         out_illegal <= 1'b0;
      end else begin
         out_valid   <= take;
         out_illegal <= in_valid && !dec.legal;
         if (take) begin
            out_data <= ext_val;
            out_rd   <= rd_idx;
         end
      end
   end

   // R1: every strobe gets exactly one response one cycle later
   a_r1_one_response: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (out_valid ^ out_illegal));

   // R1: no response without a strobe
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && !out_illegal));

   a_r3_sign_byte: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(in_insn[14:12]) == 3'b000)
         |-> out_data[XLEN-1:BYTE_W] == {(XLEN-BYTE_W){out_data[BYTE_W-1]}});

   a_r4_sign_half: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(in_insn[14:12]) == 3'b001)
         |-> out_data[XLEN-1:HALF_W] == {(XLEN-HALF_W){out_data[HALF_W-1]}});

   a_r5_zero_byte: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(in_insn[14:12]) == 3'b100)
         |-> out_data[XLEN-1:BYTE_W] == '0);

   a_r6_zero_half: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(in_insn[14:12]) == 3'b101)
         |-> out_data[XLEN-1:HALF_W] == '0);

   a_r10_hold_on_reject: assert property (@(posedge clk) disable iff (rst)
      out_illegal |-> ($stable(out_data) && $stable(out_rd)));

   a_r11_reset_clears: assert property (@(posedge clk)
      rst |=> (out_data == '0 && out_rd == '0 && !out_valid && !out_illegal));

endmodule

// File: tb/tb_narrow_arith_unit.sv
module tb_narrow_arith_unit;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] in_insn = '0;
   logic [31:0] in_src_a = '0;
   logic [31:0] in_src_b = '0;
   logic [31:0] out_data;
   logic [3:0]  out_rd;
   logic        out_valid;
   logic        out_illegal;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   narrow_arith_unit dut (
      .clk, .rst, .in_valid, .in_insn, .in_src_a, .in_src_b,
      .out_data, .out_rd, .out_valid, .out_illegal
   );

   function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [2:0] f3,
                                         input logic [4:0] rs2, input logic [4:0] rs1,
                                         input logic [4:0] rd);
      return {f7, rs2, rs1, f3, rd, 7'b0111011};
   endfunction

   function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                         input logic [2:0] f3, input logic [4:0] rd);
      return {imm, rs1, f3, rd, 7'b0011011};
   endfunction

   typedef struct packed {
      logic [31:0] insn;
      logic [31:0] a;
      logic [31:0] b;
      logic        ok;
      logic [31:0] data;
      logic [3:0]  rd;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VECS [NV] = '{
      // R3 add, sign byte
      '{enc_r(7'h00, 3'b000, 5'd2, 5'd1, 5'd5), 32'h0000007F, 32'h1, 1'b1, 32'hFFFFFF80, 4'd5, 8'd3},
      // R2 subtract, sign byte
      '{enc_r(7'h20, 3'b000, 5'd2, 5'd1, 5'd3), 32'h10, 32'h20, 1'b1, 32'hFFFFFFF0, 4'd3, 8'd2},
      // R4 add, sign half
      '{enc_r(7'h00, 3'b001, 5'd4, 5'd6, 5'd15), 32'h12347FFF, 32'h1, 1'b1, 32'hFFFF8000, 4'd15, 8'd4},
      // R2 subtract, sign half
      '{enc_r(7'h20, 3'b001, 5'd4, 5'd6, 5'd1), 32'h5, 32'h3, 1'b1, 32'h2, 4'd1, 8'd2},
      // R5 add, zero byte
      '{enc_r(7'h00, 3'b100, 5'd7, 5'd8, 5'd2), 32'hFFFFFFF0, 32'h20, 1'b1, 32'h10, 4'd2, 8'd5},
      // R5 subtract, zero byte
      '{enc_r(7'h20, 3'b100, 5'd7, 5'd8, 5'd7), 32'h0, 32'h1, 1'b1, 32'hFF, 4'd7, 8'd5},
      // R6 add, zero half
      '{enc_r(7'h00, 3'b101, 5'd9, 5'd10, 5'd9), 32'h8000, 32'h8000, 1'b1, 32'h0, 4'd9, 8'd6},
      // R6 subtract, zero half
      '{enc_r(7'h20, 3'b101, 5'd9, 5'd10, 5'd4), 32'h10000, 32'h1, 1'b1, 32'hFFFF, 4'd4, 8'd6},
      // R7 byte immediate, signed type, b ignored
      '{enc_i(12'h07F, 5'd3, 3'b000, 5'd8), 32'h1, 32'hDEADBEEF, 1'b1, 32'hFFFFFF80, 4'd8, 8'd7},
      // R7 byte immediate, unsigned type
      '{enc_i(12'h0FF, 5'd3, 3'b100, 5'd10), 32'h102, 32'h5555, 1'b1, 32'h1, 4'd10, 8'd7},
      // R8 halfword immediate -1
      '{enc_i(12'hFFF, 5'd3, 3'b001, 5'd11), 32'h0, 32'h0, 1'b1, 32'hFFFFFFFF, 4'd11, 8'd8},
      // R8 negative immediate, zero half
      '{enc_i(12'h800, 5'd3, 3'b101, 5'd12), 32'h0, 32'h0, 1'b1, 32'h0000F800, 4'd12, 8'd8},
      // R8 positive immediate
      '{enc_i(12'h7FF, 5'd3, 3'b001, 5'd13), 32'h7900, 32'h0, 1'b1, 32'hFFFF80FF, 4'd13, 8'd8},
      // R8 nonzero top nibble accepted for halfword immediate
      '{enc_i(12'hF10, 5'd3, 3'b101, 5'd14), 32'h100, 32'h0, 1'b1, 32'h10, 4'd14, 8'd8},
      // R9 byte immediate with nonzero top nibble
      '{enc_i(12'h101, 5'd3, 3'b000, 5'd5), 32'h1, 32'h0, 1'b0, 32'h0, 4'd0, 8'd9},
      // R9 bad funct7
      '{enc_r(7'h01, 3'b000, 5'd2, 5'd1, 5'd5), 32'h1, 32'h1, 1'b0, 32'h0, 4'd0, 8'd9},
      // R9 bad funct3
      '{enc_r(7'h00, 3'b010, 5'd2, 5'd1, 5'd5), 32'h1, 32'h1, 1'b0, 32'h0, 4'd0, 8'd9},
      // R9 rd of 16
      '{enc_r(7'h00, 3'b000, 5'd2, 5'd1, 5'd16), 32'h1, 32'h1, 1'b0, 32'h0, 4'd0, 8'd9},
      // R9 rs1 of 17
      '{enc_i(12'h001, 5'd17, 3'b101, 5'd5), 32'h1, 32'h0, 1'b0, 32'h0, 4'd0, 8'd9},
      // R9 rs2 of 31 in register form
      '{enc_r(7'h00, 3'b000, 5'd31, 5'd1, 5'd5), 32'h1, 32'h1, 1'b0, 32'h0, 4'd0, 8'd9},
      // R9 foreign opcode
      '{enc_r(7'h00, 3'b000, 5'd2, 5'd1, 5'd5) ^ 32'h8, 32'h1, 32'h1, 1'b0, 32'h0, 4'd0, 8'd9},
      // R9 immediate with funct3 110
      '{enc_i(12'h001, 5'd1, 3'b110, 5'd5), 32'h1, 32'h0, 1'b0, 32'h0, 4'd0, 8'd9},
      // R10 destination zero after rejections
      '{enc_i(12'h001, 5'd1, 3'b100, 5'd0), 32'hFF, 32'h0, 1'b1, 32'h0, 4'd0, 8'd10},
      // R9 rs2 field of 16 is not checked in immediate forms
      '{enc_i(12'h010, 5'd2, 3'b001, 5'd6), 32'hFFFF7FF0, 32'h0, 1'b1, 32'hFFFF8000, 4'd6, 8'd9}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   logic [31:0] last_data = '0;
   logic [3:0]  last_rd   = '0;

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 reset data", out_data, 32'h0);
      chk("R11 reset rd", {28'h0, out_rd}, 32'h0);
      chk("R11 reset flags", {30'h0, out_valid, out_illegal}, 32'h0);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
         @(negedge clk);
         in_insn  = VECS[i].insn;
         in_src_a = VECS[i].a;
         in_src_b = VECS[i].b;
         in_valid = 1'b1;
         @(negedge clk);
         in_valid = 1'b0;
         if (VECS[i].ok) begin
            chk({tag, " flags"}, {30'h0, out_valid, out_illegal}, 32'h2);
            chk({tag, " data"}, out_data, VECS[i].data);
            chk({tag, " rd"}, {28'h0, out_rd}, {28'h0, VECS[i].rd});
            last_data = VECS[i].data;
            last_rd   = VECS[i].rd;
         end else begin
            chk({tag, " flags"}, {30'h0, out_valid, out_illegal}, 32'h1);
            chk({tag, " held data"}, out_data, last_data);
            chk({tag, " held rd"}, {28'h0, out_rd}, {28'h0, last_rd});
         end
      end

      // R1 / R10: legal word without a strobe changes nothing
      in_insn  = enc_r(7'h00, 3'b101, 5'd2, 5'd1, 5'd9);
      in_src_a = 32'h1234;
      in_src_b = 32'h1;
      @(negedge clk);
      chk("R1 idle flags", {30'h0, out_valid, out_illegal}, 32'h0);
      chk("R10 idle data held", out_data, last_data);
      chk("R10 idle rd held", {28'h0, out_rd}, {28'h0, last_rd});

      // R1 back-to-back strobes
      in_insn  = enc_r(7'h00, 3'b000, 5'd2, 5'd1, 5'd1);
      in_src_a = 32'h1;
      in_src_b = 32'h1;
      in_valid = 1'b1;
      @(negedge clk);
      chk("R1 b2b first data", out_data, 32'h2);
      chk("R1 b2b first flags", {30'h0, out_valid, out_illegal}, 32'h2);
      in_insn  = enc_r(7'h20, 3'b101, 5'd2, 5'd1, 5'd2);
      in_src_a = 32'h0;
      in_src_b = 32'h1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R6 b2b second data", out_data, 32'hFFFF);
      chk("R10 b2b second rd", {28'h0, out_rd}, 32'h2);
      chk("R1 b2b second flags", {30'h0, out_valid, out_illegal}, 32'h2);

      // R11 reset overrides a strobe
      rst      = 1'b1;
      in_valid = 1'b1;
      @(negedge clk);
      rst      = 1'b0;
      in_valid = 1'b0;
      chk("R11 reset over strobe data", out_data, 32'h0);
      chk("R11 reset over strobe rd", {28'h0, out_rd}, 32'h0);
      chk("R11 reset over strobe flags", {30'h0, out_valid, out_illegal}, 32'h0);

      @(negedge clk);
      done = 1'b1;
      finish_run();
   end

endmodule